// File: doc/BRIEF.md
# Nested Loop End-Point Flag Walker

This block steps through a row-major nest of three index loops, one element per step. The innermost loop is x, the middle loop is y and the outermost loop is z. Each loop has an extent from 1 to 8, so a run covers between 1 and 512 elements. For each element the block reports the three per-loop counters, the linear element index, and a 4-bit condition field. Each bit of that field marks the end of one loop level, and one more bit marks the very last element. A control sequencer can branch on these bits to close its own loops without computing any bounds itself.

A `start` pulse latches the three extents and presents element 0. Each `step` pulse then moves to the next element. Stepping past the final element ends the run: the block raises `done` and stays idle until the next `start`. Every output is registered.

Top module: `nest_flag_walker`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `busy`, `done`, `flags`, `lin_idx` and all three counters are zero.
- R2: A `start` sampled at a clock edge latches the extents and presents element 0 after that edge, with `busy`=1 and `done`=0. An extent of 0 is taken as 1, and an extent above 8 is taken as 8.
- R3: Each `step` while `busy` moves to the next element in row-major order. x advances on every step. y advances only when x wraps, and z advances only when both x and y wrap. `lin_idx` equals x + ex*(y + ey*z) and rises by one on each step.
- R4: `flags[0]` (inner end) is 1 exactly on the elements where x = ex-1.
- R5: `flags[1]` (middle end) is 1 exactly on the elements where x = ex-1 and y = ey-1.
- R6: `flags[2]` (outer end) is 1 exactly on the elements where x, y and z are all at their last values.
- R7: `flags[3]` (final element) is 1 only on the element with `lin_idx` = ex*ey*ez-1. It is therefore set once per run.
- R8: A `step` on the final element ends the run at the next edge: `busy`=0, `done`=1, and `flags`, `lin_idx` and the counters all return to 0.
- R9: While the block is not `busy`, `step` has no effect. `done` and all other outputs hold until a `start`.
- R10: When `start` and `step` arrive in the same cycle, `start` wins. A `start` while `busy` restarts the run at element 0 with the new extents.
- R11: An extent of 1 is legal. Such a loop ends on every one of its iterations, so its flag bit is set each time all the loops inside it wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch extents and begin at element 0 |
| step | input | 1 | Advance to the next element |
| ext_x | input | 4 | Innermost loop extent |
| ext_y | input | 4 | Middle loop extent |
| ext_z | input | 4 | Outermost loop extent |
| busy | output | 1 | A run is in progress and outputs describe a live element |
| done | output | 1 | The last run completed |
| cnt_x | output | 3 | Innermost counter |
| cnt_y | output | 3 | Middle counter |
| cnt_z | output | 3 | Outermost counter |
| lin_idx | output | 9 | Linear element index |
| flags | output | 4 | {final, outer end, middle end, inner end} |

## Verification
Every result is due exactly one clock edge after the `start` or `step` that caused it. This holds for the counters, the index, the flags, `busy` and `done`, because each is a single register stage. The bench drives its inputs on the falling edge, holds them across one rising edge, and samples at the next falling edge, so each check sees the state produced by exactly one stimulus. The expected counters and flags for element i are computed from i and the extents by division and remainder, without stepping a model of the counters.

// File: rtl/nfw_pkg.sv
package nfw_pkg;

  localparam int NEST_LEVELS = 3;

  // Per-element condition field; bit order is part of the port contract.
  typedef struct packed {
    logic last_elem;   // bit 3
    logic outer_end;   // bit 2
    logic mid_end;     // bit 1
    logic inner_end;   // bit 0
  } nfw_flags_t;

  localparam nfw_flags_t NFW_FLAGS_NONE = '{default: 1'b0};

endpackage

// File: rtl/nfw_wrap_counter.sv
module nfw_wrap_counter #(
  parameter int CW = 3,
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [EW-1:0] lim,
  output logic [CW-1:0] cnt_q,
  output logic          at_end,
  output logic          at_end_nx
);

  logic [EW-1:0] lim_m1;
  logic [CW-1:0] cnt_d;

  assign lim_m1 = lim - EW'(1);
  assign at_end = (cnt_q == lim_m1[CW-1:0]);

  always_comb begin
    if (clr)
      cnt_d = '0;
    else if (inc)
      cnt_d = at_end ? '0 : cnt_q + CW'(1);
    else
      cnt_d = cnt_q;
  end

  assign at_end_nx = (cnt_d == lim_m1[CW-1:0]);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

endmodule

// File: rtl/nfw_flag_encode.sv
module nfw_flag_encode
  import nfw_pkg::*;
(
  input  logic [NEST_LEVELS-1:0] lvl_end,
  output nfw_flags_t             flg
);

  logic [NEST_LEVELS-1:0] cum_end;

  // A level ends only when it and every level inside it are at their end.
  always_comb begin
    cum_end[0] = lvl_end[0];
    for (int k = 1; k < NEST_LEVELS; k++)
      cum_end[k] = cum_end[k-1] & lvl_end[k];
  end

  always_comb begin
    flg.inner_end = cum_end[0];
    flg.mid_end   = cum_end[1];
    flg.outer_end = cum_end[2];
    flg.last_elem = cum_end[NEST_LEVELS-1];
  end

endmodule

// File: rtl/nfw_lin_index.sv
module nfw_lin_index #(
  parameter int IW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [IW-1:0] idx_q
);

  always_ff @(posedge clk) begin
    if (rst)
      idx_q <= '0;
    else if (clr)
      idx_q <= '0;
    else if (inc)
      idx_q <= idx_q + IW'(1);
  end

endmodule

// File: rtl/nest_flag_walker.sv
module nest_flag_walker
  import nfw_pkg::*;
#(
  parameter int MAX_EXT = 8,
  localparam int EXT_W  = $clog2(MAX_EXT + 1),
  localparam int CNT_W  = $clog2(MAX_EXT),
  localparam int IDX_W  = $clog2(MAX_EXT * MAX_EXT * MAX_EXT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             step,
  input  logic [EXT_W-1:0] ext_x,
  input  logic [EXT_W-1:0] ext_y,
  input  logic [EXT_W-1:0] ext_z,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] cnt_x,
  output logic [CNT_W-1:0] cnt_y,
  output logic [CNT_W-1:0] cnt_z,
  output logic [IDX_W-1:0] lin_idx,
  output logic [3:0]       flags
);

  logic [EXT_W-1:0] ext_in  [NEST_LEVELS];
  logic [EXT_W-1:0] ext_cl  [NEST_LEVELS];
  logic [EXT_W-1:0] ext_q   [NEST_LEVELS];
  logic [EXT_W-1:0] lim_sel [NEST_LEVELS];
  logic [CNT_W-1:0] cnt_q   [NEST_LEVELS];
  logic [NEST_LEVELS-1:0] lvl_inc;
  logic [NEST_LEVELS-1:0] lvl_end;
  logic [NEST_LEVELS-1:0] lvl_end_nx;

  logic       busy_q, done_q;
  logic       step_go, last_now, run_end, clr_all;
  nfw_flags_t flags_nx, flags_q;

  assign ext_in[0] = ext_x;
  assign ext_in[1] = ext_y;
  assign ext_in[2] = ext_z;

  assign step_go  = step & busy_q & ~start;
  assign last_now = &lvl_end;
  assign run_end  = step_go & last_now;
  assign clr_all  = start | run_end;

  for (genvar d = 0; d < NEST_LEVELS; d++) begin : g_lvl
    // Out-of-range extents are folded into the legal 1..MAX_EXT range.
    always_comb begin
      if (ext_in[d] == '0)
        ext_cl[d] = EXT_W'(1);
      else if (ext_in[d] > EXT_W'(MAX_EXT))
        ext_cl[d] = EXT_W'(MAX_EXT);
      else
        ext_cl[d] = ext_in[d];
    end

    always_ff @(posedge clk) begin
      if (rst)
        ext_q[d] <= EXT_W'(1);
      else if (start)
        ext_q[d] <= ext_cl[d];
    end

    assign lim_sel[d] = start ? ext_cl[d] : ext_q[d];

    if (d == 0) begin : g_inner
      assign lvl_inc[d] = step_go;
    end else begin : g_outer
      assign lvl_inc[d] = lvl_inc[d-1] & lvl_end[d-1];
    end

    nfw_wrap_counter #(
      .CW (CNT_W),
      .EW (EXT_W)
    ) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .clr       (clr_all),
      .inc       (lvl_inc[d]),
      .lim       (lim_sel[d]),
      .cnt_q     (cnt_q[d]),
      .at_end    (lvl_end[d]),
      .at_end_nx (lvl_end_nx[d])
    );
  end

  nfw_lin_index #(
    .IW (IDX_W)
  ) u_idx (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr_all),
    .inc   (step_go),
    .idx_q (lin_idx)
  );

  nfw_flag_encode u_enc (
    .lvl_end (lvl_end_nx),
    .flg     (flags_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      flags_q <= NFW_FLAGS_NONE;
    end else if (start) begin
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      flags_q <= flags_nx;
    end else if (run_end) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b1;
      flags_q <= NFW_FLAGS_NONE;
    end else if (step_go) begin
      flags_q <= flags_nx;
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign flags = flags_q;
  assign cnt_x = cnt_q[0];
  assign cnt_y = cnt_q[1];
  assign cnt_z = cnt_q[2];

endmodule

// File: rtl/nfw_checker.sv
module nfw_checker #(
  parameter int IW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          step,
  input logic          busy,
  input logic          done,
  input logic [IW-1:0] lin_idx,
  input logic [3:0]    flags
);

  assert_mid_implies_inner_R5: assert property (@(posedge clk) disable iff (rst)
    flags[1] |-> flags[0]);

  assert_outer_implies_mid_R6: assert property (@(posedge clk) disable iff (rst)
    flags[2] |-> flags[1]);

  assert_last_implies_outer_R7: assert property (@(posedge clk) disable iff (rst)
    flags[3] |-> flags[2]);

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && !done && lin_idx == '0));

  assert_index_rises_R3: assert property (@(posedge clk) disable iff (rst)
    (step && busy && !start && !flags[3]) |=> (lin_idx == IW'($past(lin_idx) + 1'b1)));

  assert_run_end_R8: assert property (@(posedge clk) disable iff (rst)
    (step && busy && !start && flags[3]) |=> (done && !busy && flags == 4'd0 && lin_idx == '0));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(done) && $stable(lin_idx) && !busy));

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind nest_flag_walker nfw_checker #(.IW(IDX_W)) u_nfw_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .step    (step),
  .busy    (busy),
  .done    (done),
  .lin_idx (lin_idx),
  .flags   (flags)
);

// File: tb/nest_flag_walker_tb.sv
`timescale 1ns/1ps
module nest_flag_walker_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       step = 1'b0;
  logic [3:0] ext_x = 4'd1, ext_y = 4'd1, ext_z = 4'd1;
  logic       busy, done;
  logic [2:0] cnt_x, cnt_y, cnt_z;
  logic [8:0] lin_idx;
  logic [3:0] flags;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  nest_flag_walker u_dut (
    .clk(clk), .rst(rst), .start(start), .step(step),
    .ext_x(ext_x), .ext_y(ext_y), .ext_z(ext_z),
    .busy(busy), .done(done), .cnt_x(cnt_x), .cnt_y(cnt_y), .cnt_z(cnt_z),
    .lin_idx(lin_idx), .flags(flags)
  );

  // Extent triples {ex, ey, ez}, one hex digit each.
  localparam logic [11:0] CASES [0:6] = '{
    12'h573, 12'h888, 12'h111, 12'h141, 12'h312, 12'h221, 12'h818
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_start(input int x, input int y, input int z, input bit with_step);
    @(negedge clk);
    start = 1'b1; step = with_step;
    ext_x = 4'(x); ext_y = 4'(y); ext_z = 4'(z);
    @(negedge clk);
    start = 1'b0; step = 1'b0;
  endtask

  task automatic do_step();
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  function automatic logic [3:0] exp_flags(input int i, input int ex, input int ey, input int ez);
    int x, y, z;
    bit xe, ye, ze;
    x = i % ex; y = (i / ex) % ey; z = i / (ex * ey);
    xe = (x == ex - 1); ye = (y == ey - 1); ze = (z == ez - 1);
    return {xe & ye & ze, xe & ye & ze, xe & ye, xe};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
    chk(lin_idx == 0 && flags == 0, "R1 idx/flags", lin_idx, 0);
    chk(cnt_x == 0 && cnt_y == 0 && cnt_z == 0, "R1 counters", cnt_x, 0);

    // R9 step while idle has no effect
    do_step();
    chk(!busy && !done && lin_idx == 0, "R9 idle step", lin_idx, 0);

    // Table walk: R3 R4 R5 R6 R7 R8 R11
    for (int c = 0; c < 7; c++) begin
      int ex, ey, ez, n, n0, n1, n2, n3;
      ex = int'(CASES[c][11:8]); ey = int'(CASES[c][7:4]); ez = int'(CASES[c][3:0]);
      n = ex * ey * ez;
      n0 = 0; n1 = 0; n2 = 0; n3 = 0;
      do_start(ex, ey, ez, 1'b0);
      chk(busy && !done, "R2 start busy", busy, 1);
      for (int i = 0; i < n; i++) begin
        chk(lin_idx == 9'(i), "R3 lin_idx", lin_idx, i);
        chk(cnt_x == 3'(i % ex) && cnt_y == 3'((i / ex) % ey) && cnt_z == 3'(i / (ex * ey)),
            "R3 counters x", cnt_x, i % ex);
        chk(flags == exp_flags(i, ex, ey, ez), "R4 R5 R6 R7 R11 flags", flags, exp_flags(i, ex, ey, ez));
        n0 += int'(flags[0]); n1 += int'(flags[1]); n2 += int'(flags[2]); n3 += int'(flags[3]);
        do_step();
      end
      chk(n0 == ey * ez, "R4 R11 inner-end count", n0, ey * ez);
      chk(n1 == ez, "R5 R11 mid-end count", n1, ez);
      chk(n2 == 1, "R6 outer-end count", n2, 1);
      chk(n3 == 1, "R7 last count", n3, 1);
      chk(done && !busy, "R8 done after last", {busy, done}, 1);
      chk(lin_idx == 0 && flags == 0 && cnt_x == 0 && cnt_y == 0 && cnt_z == 0,
          "R8 cleared", lin_idx, 0);
    end

    // R9 done holds and steps are ignored
    do_step(); do_step();
    chk(done && !busy && lin_idx == 0 && flags == 0, "R9 done hold", done, 1);

    // R2 zero extents folded to 1: single element with every flag
    do_start(0, 0, 0, 1'b0);
    chk(flags == 4'b1111 && lin_idx == 0, "R2 zero extents", flags, 15);
    do_step();
    chk(done, "R8 single element end", done, 1);

    // R2 extent above 8 folded to 8
    do_start(15, 1, 1, 1'b0);
    for (int i = 0; i < 7; i++) do_step();
    chk(flags == 4'b1111 && lin_idx == 7 && cnt_x == 7, "R2 clamp to 8", lin_idx, 7);

    // R10 start with step restarts at element 0 with new extents
    do_start(4, 2, 2, 1'b0);
    do_step(); do_step();
    chk(lin_idx == 2, "R3 mid-run", lin_idx, 2);
    do_start(2, 3, 1, 1'b1);
    chk(lin_idx == 0 && cnt_x == 0 && busy && !done, "R10 start priority", lin_idx, 0);
    do_step();
    chk(flags == 4'b0001 && cnt_x == 1, "R10 new extents", flags, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule